// File: doc/BRIEF.md
# Two-Byte Read Line Buffer for an 8-bit CPU on 16-bit Memory

This block sits between a byte-wide CPU bus and a 16-bit-wide synchronous memory with a fixed read latency. It acts as a fully associative cache holding a single line of two bytes. Every memory read through the block fetches a whole even-aligned 16-bit word. The block keeps that word together with its word address.

A later CPU read of either byte of that word is answered from the line in the same cycle, with no memory access. A read that misses holds off the CPU through the ready signal until the memory latency has elapsed. Writes go straight through to memory as single-byte writes. If a write lands in the buffered word, it also patches the buffered copy. An address window decoded inside the block marks I/O space, and I/O accesses always go to the bus as byte accesses without touching the line.

Code that walks upward through memory gains the most. An even-address miss turns the following odd-address read into a hit. An odd-address miss costs a full memory access like any other miss.

Top module: `byte_line_buffer`

## Requirements
- R1: After reset the line holds no valid word. With no request, cpu_ready, mem_rd and mem_wr are low, and the first read of any address misses.
- R2: A read miss pulses mem_rd for one cycle, in the request cycle. mem_addr is cpu_addr[15:1] and mem_be is 2'b11. cpu_ready rises exactly LAT cycles later, and cpu_rdata is mem_rdata[7:0] when cpu_addr[0]=0 or mem_rdata[15:8] when cpu_addr[0]=1.
- R3: A read whose address bits [15:1] equal the stored word address while the line is valid is a hit. cpu_ready is high in the request cycle, no memory read is issued, and the correct buffered byte is returned.
- R4: After an even-address miss, the odd byte of the same word hits. After an odd-address miss the read still takes the full LAT cycles, and the even byte of that word then hits.
- R5: A miss to a different word replaces the line, so the previously buffered word misses afterwards.
- R6: A write completes in its request cycle (cpu_ready high) with a one-cycle mem_wr. mem_be is 2'b01 for an even address and 2'b10 for an odd one, and mem_wdata carries the byte in both halves.
- R7: A write to the buffered word updates the matching buffered byte, so a later hit returns the written value.
- R8: A write to any other word leaves the line unchanged, and the buffered word still hits with its old contents.
- R9: A read with (cpu_addr & 16'hFF00) == 16'hFE00 is an I/O read. It never hits and always takes a memory read of LAT cycles with one byte enable (2'b01 even, 2'b10 odd). It does not load the line, so the previously buffered word still hits.
- R10: A write to the I/O window goes to memory but changes neither the buffered bytes nor the valid state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | AW | CPU byte address, held until cpu_ready |
| cpu_rd | input | 1 | Read request, held until cpu_ready |
| cpu_wr | input | 1 | Write request, wins over cpu_rd |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid while cpu_ready is high on a read |
| cpu_ready | output | 1 | Request completes at the end of this cycle |
| mem_addr | output | AW-1 | Memory word address |
| mem_rd | output | 1 | Memory read issue strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_be | output | 2 | Byte enables, bit 0 for the low byte |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word, valid LAT cycles after mem_rd |

## Verification
The two functions that can meet are the hit path and the coherence path. A write to the buffered word updates a byte, and the very next read request must see that byte through a same-cycle hit. The bench provokes this by loading a word with a miss, writing one of its bytes, and reading both bytes back at once. It judges each read by its latency in cycles, by the count of memory reads observed on mem_rd, and by the byte value computed from the bench's own reference array. The same timing meeting is provoked on the I/O side: an I/O read or write lands between loading a word and re-reading it.

// File: rtl/blb_pkg.sv
package blb_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } blb_state_e;

   localparam int unsigned LANES = 2;
   localparam int unsigned BYTE_W = 8;

   function automatic logic [LANES-1:0] lane_onehot(input logic lane);
      lane_onehot = lane ? 2'b10 : 2'b01;
   endfunction
endpackage

// File: rtl/blb_io_dec.sv
module blb_io_dec #(
   parameter int unsigned AW = 16,
   parameter bit IO_EN = 1'b1,
   parameter logic [AW-1:0] IO_MASK = 16'hFF00,
   parameter logic [AW-1:0] IO_MATCH = 16'hFE00
) (
   input  logic [AW-1:0] addr,
   output logic          is_io
);
   generate
      if (IO_EN) begin : g_dec
         assign is_io = ((addr & IO_MASK) == IO_MATCH);
      end else begin : g_none
         logic unused_addr;
         assign unused_addr = ^addr;
         assign is_io = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/blb_lat.sv
module blb_lat #(
   parameter int unsigned LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   generate
      if (LAT == 1) begin : g_one
         logic busy_q;
         always_ff @(posedge clk) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= start;
         end
         assign done = busy_q;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(LAT);
         logic          busy_q;
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else if (start) begin
               busy_q <= 1'b1;
               cnt_q  <= CW'(LAT - 1);
            end else if (busy_q) begin
               if (cnt_q == '0) busy_q <= 1'b0;
               else             cnt_q  <= cnt_q - 1'b1;
            end
         end
         assign done = busy_q && (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/blb_line.sv
module blb_line #(
   parameter int unsigned TW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] look_tag,
   output logic          hit,
   output logic [15:0]   line_word,
   input  logic          fill_en,
   input  logic [TW-1:0] fill_tag,
   input  logic [15:0]   fill_word,
   input  logic          wr_en,
   input  logic          wr_lane,
   input  logic [7:0]    wr_byte
);
   import blb_pkg::*;

   logic          valid_q;
   logic [TW-1:0] tag_q;

   assign hit = valid_q && (tag_q == look_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
      end else if (fill_en) begin
         valid_q <= 1'b1;
         tag_q   <= fill_tag;
      end
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [BYTE_W-1:0] byte_q;
         logic              patch;
         assign patch = wr_en && hit && (wr_lane == l[0]);
         always_ff @(posedge clk) begin
            if (!rst_n)       byte_q <= '0;
            else if (fill_en) byte_q <= fill_word[l*BYTE_W +: BYTE_W];
            else if (patch)   byte_q <= wr_byte;
         end
         assign line_word[l*BYTE_W +: BYTE_W] = byte_q;
      end
   endgenerate
endmodule

// File: rtl/byte_line_buffer.sv
module byte_line_buffer #(
   parameter int unsigned   AW       = 16,
   parameter int unsigned   LAT      = 2,
   parameter bit            IO_EN    = 1'b1,
   parameter logic [AW-1:0] IO_MASK  = 16'hFF00,
   parameter logic [AW-1:0] IO_MATCH = 16'hFE00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_rd,
   input  logic          cpu_wr,
   input  logic [7:0]    cpu_wdata,
   output logic [7:0]    cpu_rdata,
   output logic          cpu_ready,
   output logic [AW-2:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [1:0]    mem_be,
   output logic [15:0]   mem_wdata,
   input  logic [15:0]   mem_rdata
);
   import blb_pkg::*;

   localparam int unsigned TW = AW - 1;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("byte_line_buffer: AW must be at least 2");
      end
      if (LAT < 1) begin : g_bad_lat
         $error("byte_line_buffer: LAT must be at least 1");
      end
   endgenerate

   blb_state_e    state_q;
   logic          req_lane_q;
   logic          req_io_q;
   logic [TW-1:0] req_tag_q;

   logic          is_io;
   logic          hit;
   logic [15:0]   line_word;
   logic          idle;
   logic          wr_go;
   logic          rd_go;
   logic          rd_hit;
   logic          rd_miss;
   logic          lat_done;
   logic          fill_done;
   logic [TW-1:0] cur_tag;

   assign cur_tag = cpu_addr[AW-1:1];

   blb_io_dec #(
      .AW(AW), .IO_EN(IO_EN), .IO_MASK(IO_MASK), .IO_MATCH(IO_MATCH)
   ) u_dec (
      .addr (cpu_addr),
      .is_io(is_io)
   );

   assign idle      = (state_q == ST_IDLE);
   assign wr_go     = idle && cpu_wr;
   assign rd_go     = idle && cpu_rd && !cpu_wr;
   assign rd_hit    = rd_go && hit && !is_io;
   assign rd_miss   = rd_go && !(hit && !is_io);
   assign fill_done = (state_q == ST_WAIT) && lat_done;

   blb_lat #(.LAT(LAT)) u_lat (
      .clk  (clk),
      .rst_n(rst_n),
      .start(rd_miss),
      .done (lat_done)
   );

   blb_line #(.TW(TW)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .look_tag (cur_tag),
      .hit      (hit),
      .line_word(line_word),
      .fill_en  (fill_done && !req_io_q),
      .fill_tag (req_tag_q),
      .fill_word(mem_rdata),
      .wr_en    (wr_go && !is_io),
      .wr_lane  (cpu_addr[0]),
      .wr_byte  (cpu_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         req_lane_q <= 1'b0;
         req_io_q   <= 1'b0;
         req_tag_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (rd_miss) begin
               state_q    <= ST_WAIT;
               req_lane_q <= cpu_addr[0];
               req_io_q   <= is_io;
               req_tag_q  <= cur_tag;
            end
            ST_WAIT: if (lat_done) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      if (fill_done)
         cpu_rdata = req_lane_q ? mem_rdata[15:8] : mem_rdata[7:0];
      else
         cpu_rdata = cpu_addr[0] ? line_word[15:8] : line_word[7:0];
   end

   assign cpu_ready = wr_go || rd_hit || fill_done;
   assign mem_addr  = cur_tag;
   assign mem_rd    = rd_miss;
   assign mem_wr    = wr_go;
   assign mem_wdata = {cpu_wdata, cpu_wdata};
   assign mem_be    = (wr_go || is_io) ? lane_onehot(cpu_addr[0]) : 2'b11;
endmodule

// File: rtl/blb_checker.sv
module blb_checker #(
   parameter int unsigned   AW       = 16,
   parameter int unsigned   LAT      = 2,
   parameter bit            IO_EN    = 1'b1,
   parameter logic [AW-1:0] IO_MASK  = 16'hFF00,
   parameter logic [AW-1:0] IO_MATCH = 16'hFE00
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] cpu_addr,
   input logic          cpu_wr,
   input logic          cpu_ready,
   input logic [AW-2:0] mem_addr,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [1:0]    mem_be
);
   logic        pend_q;
   logic [15:0] cnt_q;
   logic        io_addr;

   assign io_addr = IO_EN && ((cpu_addr & IO_MASK) == IO_MATCH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (mem_rd) begin
         pend_q <= 1'b1;
         cnt_q  <= 16'd1;
      end else if (pend_q) begin
         if (cnt_q == 16'(LAT)) pend_q <= 1'b0;
         else                   cnt_q  <= cnt_q + 16'd1;
      end
   end

   AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && cpu_ready)); // R3
   AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && cnt_q < 16'(LAT)) |-> !cpu_ready); // R2
   AST_MISS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && cnt_q == 16'(LAT)) |-> cpu_ready); // R2
   AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (mem_addr == cpu_addr[AW-1:1])); // R2
   AST_WR_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($countones(mem_be) == 1 && mem_be[cpu_addr[0]])); // R6
   AST_WR_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !pend_q) |-> (cpu_ready && mem_wr)); // R6
   AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R6
   AST_IO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && io_addr) |-> ($countones(mem_be) == 1 && mem_be[cpu_addr[0]])); // R9
endmodule

bind byte_line_buffer blb_checker #(
   .AW(AW), .LAT(LAT), .IO_EN(IO_EN), .IO_MASK(IO_MASK), .IO_MATCH(IO_MATCH)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_addr (cpu_addr),
   .cpu_wr   (cpu_wr),
   .cpu_ready(cpu_ready),
   .mem_addr (mem_addr),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .mem_be   (mem_be)
);

// File: tb/byte_line_buffer_test.sv
`timescale 1ns/100ps
module byte_line_buffer_test;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        cpu_ready;
   logic [14:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic [1:0]  mem_be;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;

   int total = 0;
   int bad = 0;
   int rd_count = 0;
   logic [1:0] last_rd_be = '0;

   logic [15:0] memw [512];
   logic [7:0]  refb [1024];
   logic [8:0]  pipe [LAT];

   always #2.5 clk = ~clk;

   byte_line_buffer #(.AW(16), .LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   function automatic logic is_io(input logic [15:0] a);
      return (a & 16'hFF00) == 16'hFE00;
   endfunction

   function automatic logic [8:0] widx(input logic [14:0] w);
      return {is_io({w, 1'b0}), w[7:0]};
   endfunction

   function automatic logic [9:0] bidx(input logic [15:0] a);
      return {is_io(a), a[8:0]};
   endfunction

   assign mem_rdata = memw[pipe[LAT-1]];

   always @(posedge clk) begin
      pipe[0] <= widx(mem_addr);
      for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
      if (mem_rd) begin
         rd_count   <= rd_count + 1;
         last_rd_be <= mem_be;
      end
      if (mem_wr) begin
         if (mem_be[0]) memw[widx(mem_addr)][7:0]  <= mem_wdata[7:0];
         if (mem_be[1]) memw[widx(mem_addr)][15:8] <= mem_wdata[15:8];
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Read: returns cycles to ready, memory reads issued, data.
   task automatic rd(input logic [15:0] a, output int n, output int reads,
                     output logic [7:0] d);
      int r0;
      @(negedge clk);
      cpu_addr = a;
      cpu_rd   = 1'b1;
      r0 = rd_count;
      n = 0;
      #1;
      while (!cpu_ready && n < 50) begin
         @(negedge clk);
         #1;
         n++;
      end
      d = cpu_rdata;
      @(posedge clk);
      #1;
      cpu_rd = 1'b0;
      reads = rd_count - r0;
   endtask

   task automatic rd_chk(input logic [15:0] a, input logic hit, input string req);
      int n, reads;
      logic [7:0] d;
      rd(a, n, reads, d);
      check({req, " latency"}, n, hit ? 0 : LAT);
      check({req, " mem reads"}, reads, hit ? 0 : 1);
      check({req, " data"}, d, refb[bidx(a)]);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] v);
      @(negedge clk);
      cpu_addr  = a;
      cpu_wdata = v;
      cpu_wr    = 1'b1;
      #1;
      check("R6 write ready", cpu_ready, 1);
      check("R6 write strobe", mem_wr, 1);
      check("R6 write lane", mem_be, a[0] ? 2 : 1);
      check("R6 write data", a[0] ? mem_wdata[15:8] : mem_wdata[7:0], v);
      refb[bidx(a)] = v;
      @(posedge clk);
      #1;
      cpu_wr = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) refb[i] = 8'(i * 13 + 5);
      for (int i = 0; i < 512; i++) memw[i] = {refb[2*i+1], refb[2*i]};
      for (int k = 0; k < LAT; k++) pipe[k] = '0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      check("R1 ready idle", cpu_ready, 0);
      check("R1 mem_rd idle", mem_rd, 0);
      check("R1 mem_wr idle", mem_wr, 0);
      // R1 / R2: first read misses, full word fetch
      begin
         int n, reads;
         logic [7:0] d;
         @(negedge clk);
         cpu_addr = 16'h0000;
         cpu_rd = 1'b1;
         #1;
         check("R2 fetch be", mem_be, 3);
         check("R2 fetch addr", mem_addr, 0);
         cpu_rd = 1'b0;
         rd(16'h0000, n, reads, d);
         check("R1 first read latency", n, LAT);
         check("R1 first read data", d, refb[0]);
      end
      // R2 / R3: even miss then odd hit over a sweep of words
      for (int w = 1; w < 41; w++) begin
         rd_chk(16'(2*w),     1'b0, "R2 even miss");
         rd_chk(16'(2*w + 1), 1'b1, "R3 odd hit");
      end
      // R4: odd miss gives full latency, even byte then hits
      for (int w = 41; w < 61; w++) begin
         rd_chk(16'(2*w + 1), 1'b0, "R4 odd miss");
         rd_chk(16'(2*w),     1'b1, "R4 even hit after odd");
         rd_chk(16'(2*w + 1), 1'b1, "R4 odd rehit");
      end
      // R5: replacement
      rd_chk(16'h000A, 1'b0, "R5 load word 5");
      rd_chk(16'h000C, 1'b0, "R5 load word 6");
      rd_chk(16'h000B, 1'b0, "R5 word 5 evicted");
      // R7 / R8: coherence and other-word writes
      for (int w = 70; w < 90; w++) begin
         rd_chk(16'(2*w), 1'b0, "R7 load");
         wr(16'(2*w + (w % 2)), 8'(w * 7 + 3));
         rd_chk(16'(2*w + (w % 2)), 1'b1, "R7 patched byte hit");
         rd_chk(16'(2*w + 1 - (w % 2)), 1'b1, "R7 other byte hit");
         wr(16'(2*w + 40), 8'(w * 11 + 1));
         rd_chk(16'(2*w), 1'b1, "R8 other word write");
         rd_chk(16'(2*w + 1), 1'b1, "R8 other word write odd");
      end
      rd_chk(16'(2*70 + 40), 1'b0, "R8 written word reads back");
      // R9: I/O reads never hit and never fill
      rd_chk(16'h0020, 1'b0, "R9 load word 16");
      rd_chk(16'hFE04, 1'b0, "R9 io read even");
      check("R9 io be even", last_rd_be, 1);
      rd_chk(16'hFE04, 1'b0, "R9 io reread misses");
      rd_chk(16'hFE05, 1'b0, "R9 io read odd");
      check("R9 io be odd", last_rd_be, 2);
      rd_chk(16'h0021, 1'b1, "R9 line kept");
      // R10: I/O write leaves buffer intact
      wr(16'hFE05, 8'h5A);
      rd_chk(16'h0020, 1'b1, "R10 line kept even");
      rd_chk(16'h0021, 1'b1, "R10 line kept odd");
      rd_chk(16'hFE05, 1'b0, "R10 io write reached memory");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule